// File: doc/BRIEF.md
# Ingress Link Diagnostics Controller

This block gives software a handful of diagnostic levers over the ingress side of a packet link. It holds the control bits that tell the status-channel generator to send training patterns without a break and to corrupt the parity of a chosen number of status frames. A write starts the corruption run, and the request bit drops by itself once the run is finished. The block also keeps a saturating count of the data-parity errors that the ingress data checker reports. Reading that count clears it.

The block also watches the ingress word stream for long runs of training patterns. When a programmable number of back-to-back training words arrives, it raises a sticky out-of-sync flag, which software clears with a write. A threshold of zero switches this watch off. Parity computation and bit-phase alignment are done elsewhere. Only per-word strobes come in, and only control levels and pulses go out.

Register map (2-bit word address, 16-bit data): 0 = control (bit 0 force-training, bit 1 insert request / busy, bits 15:8 insert count), 1 = error count (read clears), 2 = training threshold (bits 7:0), 3 = sync status (bit 0 out-of-sync, write 1 to clear).

Top module: `link_diag_ctrl`

## Requirements
- R1: Control bit 0 drives `force_train` directly. It is 1 while the bit is set and 0 once the bit is written back to 0.
- R2: A control write with bit 1 set loads the insert count from bits 15:8. After that, `dip2_invert` pulses in the cycle of each `frame_start`, once per frame, until that many frames have been marked, and it never pulses without `frame_start`.
- R3: Control bit 1 reads back as 1 while insertions remain. It clears by itself after the last requested insertion.
- R4: Each cycle with `dip4_err` high adds one to the error count, which reads at address 1.
- R5: A read of address 1 returns the current count and leaves the count at 0 afterwards.
- R6: If `dip4_err` is high in the same cycle as a read of address 1, the read returns the old value and the count becomes 1.
- R7: The error count saturates at 0xFFFF and does not wrap.
- R8: With threshold T nonzero, the out-of-sync flag sets after T consecutive valid training words. A valid non-training word restarts the run.
- R9: The out-of-sync flag (`out_of_sync`, address 3 bit 0) stays set until a write of 1 to address 3 bit 0 clears it.
- R10: A threshold of 0 keeps the out-of-sync flag from ever setting.
- R11: After reset, control reads 0x0000, the count reads 0, the threshold reads 0x00FF and sync status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of reg_rd |
| dip4_err | input | 1 | Data-parity error strobe from the ingress checker |
| word_valid | input | 1 | An ingress data word is present |
| word_is_train | input | 1 | The present word is a training pattern |
| frame_start | input | 1 | Status-channel frame boundary from the generator |
| force_train | output | 1 | Make the status channel send training continuously |
| dip2_invert | output | 1 | Invert the parity bits of the current status frame |
| out_of_sync | output | 1 | Sticky loss-of-sync flag |

## Verification
Two functions can fall in the same cycle: an error strobe from the data checker and a software read that clears the counter. The bench provokes the overlap by raising `dip4_err` in the very cycle a read of address 1 is issued, with the count at 7. The read must return 7 and the next read must return 1, which shows the colliding error was kept and not swallowed by the clear.

// File: rtl/link_diag_pkg.sv
package link_diag_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_ECNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_THR  = 2'd2;
  localparam logic [ADDR_W-1:0] A_SYNC = 2'd3;
  localparam int CTRL_FORCE_BIT = 0;
  localparam int CTRL_INS_BIT   = 1;
  localparam int CTRL_NUM_LSB   = 8;
  localparam int SYNC_OOS_BIT   = 0;
endpackage

// File: rtl/ld_regs.sv
module ld_regs
  import link_diag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int NUM_W  = 8,
  parameter int THR_W  = 8,
  parameter logic [THR_W-1:0] THR_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              oos,
  output logic [DATA_W-1:0] rdata,
  output logic              force_q,
  output logic [NUM_W-1:0]  num_q,
  output logic [THR_W-1:0]  thr_q,
  output logic              ins_load,
  output logic              oos_clr,
  output logic              cnt_rd
);
  logic wr_ctrl, wr_thr;

  assign wr_ctrl  = wr && (addr == A_CTRL);
  assign wr_thr   = wr && (addr == A_THR);
  assign ins_load = wr_ctrl && wdata[CTRL_INS_BIT];
  assign oos_clr  = wr && (addr == A_SYNC) && wdata[SYNC_OOS_BIT];
  assign cnt_rd   = rd && (addr == A_ECNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      num_q   <= '0;
      thr_q   <= THR_RST;
    end else begin
      if (wr_ctrl) begin
        force_q <= wdata[CTRL_FORCE_BIT];
        num_q   <= wdata[CTRL_NUM_LSB +: NUM_W];
      end
      if (wr_thr) thr_q <= wdata[THR_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CTRL_FORCE_BIT]          = force_q;
        rdata[CTRL_INS_BIT]            = busy;
        rdata[CTRL_NUM_LSB +: NUM_W]   = num_q;
      end
      A_ECNT:  rdata[CNT_W-1:0] = cnt;
      A_THR:   rdata[THR_W-1:0] = thr_q;
      default: rdata[SYNC_OOS_BIT] = oos;
    endcase
  end
endmodule

// File: rtl/ld_inject.sv
module ld_inject #(
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] load_num,
  input  logic             frame,
  output logic [NUM_W-1:0] rem_q,
  output logic             busy,
  output logic             invert
);
  function automatic logic [NUM_W-1:0] rem_next(input logic [NUM_W-1:0] r,
                                               input logic ld,
                                               input logic [NUM_W-1:0] n,
                                               input logic fr);
    if (ld)                     return n;
    else if (fr && (r != '0))   return r - 1'b1;
    else                        return r;
  endfunction

  assign busy   = (rem_q != '0);
  assign invert = frame && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_next(rem_q, load, load_num, frame);
  end
endmodule

// File: rtl/ld_errcnt.sv
module ld_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                               input logic i,
                                               input logic k);
    if (k)                        return i ? CNT_W'(1) : '0;
    else if (i && c != CNT_MAX)   return c + 1'b1;
    else                          return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next(cnt_q, inc, clr);
  end
endmodule

// File: rtl/ld_syncmon.sv
module ld_syncmon #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             train,
  input  logic [THR_W-1:0] thr,
  input  logic             clr,
  output logic             hit,
  output logic             oos_q
);
  localparam logic [THR_W-1:0] RUN_MAX = '1;
  logic [THR_W-1:0] run_q, run_d;

  function automatic logic [THR_W-1:0] run_next(input logic [THR_W-1:0] r,
                                               input logic v,
                                               input logic t);
    if (!v)               return r;
    else if (!t)          return '0;
    else if (r == RUN_MAX) return r;
    else                  return r + 1'b1;
  endfunction

  assign run_d = run_next(run_q, valid, train);
  assign hit   = valid && train && (thr != '0) && (run_d >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      oos_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (hit)      oos_q <= 1'b1;
      else if (clr) oos_q <= 1'b0;
    end
  end
endmodule

// File: rtl/link_diag_ctrl.sv
module link_diag_ctrl
  import link_diag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int NUM_W  = 8,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dip4_err,
  input  logic              word_valid,
  input  logic              word_is_train,
  input  logic              frame_start,
  output logic              force_train,
  output logic              dip2_invert,
  output logic              out_of_sync
);
  logic [NUM_W-1:0] num_q, rem_q;
  logic [THR_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             force_q, ins_load, oos_clr, cnt_rd, busy, hit, oos_q;

  ld_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_W(NUM_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .cnt(cnt_q), .oos(oos_q), .rdata(reg_rdata),
    .force_q(force_q), .num_q(num_q), .thr_q(thr_q), .ins_load(ins_load),
    .oos_clr(oos_clr), .cnt_rd(cnt_rd)
  );

  ld_inject #(.NUM_W(NUM_W)) u_inj (
    .clk(clk), .rst_n(rst_n), .load(ins_load),
    .load_num(reg_wdata[CTRL_NUM_LSB +: NUM_W]), .frame(frame_start),
    .rem_q(rem_q), .busy(busy), .invert(dip2_invert)
  );

  ld_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(dip4_err), .clr(cnt_rd), .cnt_q(cnt_q)
  );

  ld_syncmon #(.THR_W(THR_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .valid(word_valid), .train(word_is_train),
    .thr(thr_q), .clr(oos_clr), .hit(hit), .oos_q(oos_q)
  );

  assign force_train = force_q;
  assign out_of_sync = oos_q;
endmodule

// File: rtl/link_diag_chk.sv
module link_diag_chk #(
  parameter int CNT_W = 16,
  parameter int NUM_W = 8,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dip4_err,
  input logic             frame_start,
  input logic             dip2_invert,
  input logic             cnt_rd,
  input logic [CNT_W-1:0] cnt_q,
  input logic [NUM_W-1:0] rem_q,
  input logic             ins_load,
  input logic [THR_W-1:0] thr_q,
  input logic             oos_q,
  input logic             oos_clr
);
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !cnt_rd) |=> (cnt_q == '1));
  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && !dip4_err) |=> (cnt_q == '0));
  // R6
  rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && dip4_err) |=> (cnt_q == CNT_W'(1)));
  // R2
  inject_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dip2_invert |-> frame_start);
  // R3
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == NUM_W'(1) && frame_start && !ins_load) |=> (rem_q == '0));
  // R10
  oos_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0 && !oos_q) |=> !oos_q);
  // R9
  oos_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oos_q && !oos_clr) |=> oos_q);
endmodule

bind link_diag_ctrl link_diag_chk #(.CNT_W(CNT_W), .NUM_W(NUM_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dip4_err(dip4_err), .frame_start(frame_start),
  .dip2_invert(dip2_invert), .cnt_rd(cnt_rd), .cnt_q(cnt_q), .rem_q(rem_q),
  .ins_load(ins_load), .thr_q(thr_q), .oos_q(oos_q), .oos_clr(oos_clr)
);

// File: tb/sim_link_diag_ctrl.sv
module sim_link_diag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dip4_err = 1'b0, word_valid = 1'b0, word_is_train = 1'b0, frame_start = 1'b0;
  logic        force_train, dip2_invert, out_of_sync;

  int checks = 0, errors = 0, pulses = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  link_diag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dip4_err(dip4_err),
    .word_valid(word_valid), .word_is_train(word_is_train), .frame_start(frame_start),
    .force_train(force_train), .dip2_invert(dip2_invert), .out_of_sync(out_of_sync)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // monitor: samples 1 ns before each rising edge
  always @(negedge clk) begin
    #4;
    if (frame_start && dip2_invert) pulses++;
    if (reg_rd) begin
      if (sb.size() == 0) check(reg_rdata, 16'hxxxx, "scoreboard empty");
      else begin
        item_t it;
        it = sb.pop_front();
        check(reg_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk); sb.push_back(it); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic word(input logic t);
    @(negedge clk); word_valid = 1'b1; word_is_train = t;
    @(negedge clk); word_valid = 1'b0;
  endtask

  task automatic errs(input int n);
    @(negedge clk); dip4_err = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); dip4_err = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd(2'd0, 16'h0000, "R11 ctrl reset");
    rd(2'd1, 16'h0000, "R11 count reset");
    rd(2'd2, 16'h00FF, "R11 threshold reset");
    rd(2'd3, 16'h0000, "R11 sync reset");
    // R1 force training
    wr(2'd0, 16'h0001);
    check({15'd0, force_train}, 16'd1, "R1 force on");
    wr(2'd0, 16'h0000);
    check({15'd0, force_train}, 16'd0, "R1 force off");
    // R2 / R3 injection of three errors
    pulses = 0;
    repeat (4) @(negedge clk);
    check(16'(pulses), 16'd0, "R2 no pulse when idle");
    wr(2'd0, 16'h0302);
    frame();
    rd(2'd0, 16'h0302, "R3 busy while pending");
    frame(); frame(); frame(); frame();
    check(16'(pulses), 16'd3, "R2 pulse count");
    rd(2'd0, 16'h0300, "R3 self clear");
    // R4 / R5 counting and clear on read
    errs(5);
    rd(2'd1, 16'd5, "R4 count five");
    rd(2'd1, 16'd0, "R5 cleared by read");
    // R6 collision
    errs(7);
    begin
      item_t it;
      it.exp = 16'd7; it.tag = "R6 read during error";
      @(negedge clk); sb.push_back(it); reg_rd = 1'b1; reg_addr = 2'd1; dip4_err = 1'b1;
      @(negedge clk); reg_rd = 1'b0; dip4_err = 1'b0;
    end
    rd(2'd1, 16'd1, "R6 error kept");
    // R7 saturation
    errs(70000);
    rd(2'd1, 16'hFFFF, "R7 saturated");
    // R8 run detection with threshold 4
    wr(2'd2, 16'h0004);
    word(1); word(1); word(1); word(0); word(1); word(1); word(1);
    check({15'd0, out_of_sync}, 16'd0, "R8 run restarted by normal word");
    word(1);
    check({15'd0, out_of_sync}, 16'd1, "R8 fourth consecutive training word");
    // R9 sticky and clear
    word(0); word(0);
    rd(2'd3, 16'h0001, "R9 flag sticky");
    wr(2'd3, 16'h0001);
    rd(2'd3, 16'h0000, "R9 flag cleared by write");
    // R10 threshold zero disables
    wr(2'd2, 16'h0000);
    for (int i = 0; i < 300; i++) word(1);
    check({15'd0, out_of_sync}, 16'd0, "R10 disabled detection");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule